// File: doc/BRIEF.md
# Status Register Write-Protect Logic

This block keeps the control and status bits that decide whether a serial non-volatile memory may be written, and turns decoded commands into accept or refuse verdicts. It holds a write-in-progress flag, a write-enable latch, a two-bit protect-size field and a status-freeze bit. It combines these with the level of an active-low write-protect pin and the address of a memory write. The command decoder in front of it presents one decoded command per clock. The write-cycle engine behind it runs the actual program cycle and reports it through a busy flag.

The protected region always grows down from the top of the address space: none, the top quarter, the top half, or everything. When the freeze bit is set and the pin is held low, status writes are refused, so the protection setting cannot be changed until the pin is released. The status byte is a live output and can be read at any time, also while a cycle is running.

Top module: `sr_guard`

## Requirements
- R1: A synchronous active-high reset clears the status byte to 0x00 and holds all four verdict outputs low.
- R2: The status byte carries write-in-progress in bit 0, the enable latch in bit 1, the protect-size field in bits 3:2 and the freeze bit in bit 7; bits 6:4 always read 0, whatever a status write carries.
- R3: Command codes on `cmd_op` are 0 idle, 1 set-enable, 2 clear-enable, 3 status write, 4 memory write, and any other value is idle. Code 1 sets the enable latch and code 2 clears it, both without any verdict pulse.
- R4: A status write with the enable latch clear is refused with a one-cycle `sr_wr_deny` pulse and changes no bit.
- R5: A status write while the freeze bit is 1 and `wp_n` is 0 is refused and leaves the protect field, freeze bit and enable latch unchanged. With `wp_n` at 1 the same write is accepted, copying data bits 7 and 3:2 into the freeze bit and protect field.
- R6: The protect field selects the refused region as 00 none, 01 addresses whose two top bits are 11, 10 addresses whose top bit is 1, 11 every address; a memory write into that region is refused with a one-cycle `mem_wr_deny` pulse.
- R7: A memory write outside the protected region with the enable latch set is accepted with a one-cycle `mem_wr_go` pulse, and write-in-progress reads 1 from the same cycle.
- R8: A refused memory or status write leaves the enable latch as it was and does not set write-in-progress.
- R9: While write-in-progress is 1, every command of codes 1 to 4 is ignored: no verdict pulse and no change to the status byte.
- R10: The clock edge at which `cyc_busy` is first seen low after being high, while write-in-progress is 1, clears both write-in-progress and the enable latch.
- R11: All verdicts and status changes appear in the cycle after the edge that samples the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Decoded command code, one per clock |
| cmd_addr | input | ADDR_W | Target address of a memory write |
| cmd_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| cyc_busy | input | 1 | Write-cycle engine busy flag |
| mem_wr_go | output | 1 | Memory write accepted, one-cycle pulse |
| mem_wr_deny | output | 1 | Memory write refused, one-cycle pulse |
| sr_wr_go | output | 1 | Status write accepted, one-cycle pulse |
| sr_wr_deny | output | 1 | Status write refused, one-cycle pulse |
| status_byte | output | 8 | Live status byte |

## Verification
Every internal bit of this block is mirrored in the status byte, so a wrong latch, protect field or progress flag shows on `status_byte` one clock after the command that corrupted it. A wrong region decode or a wrong freeze condition shows one clock later as a swapped go or deny pulse. A progress flag that fails to clear surfaces as silently ignored commands on the next write attempt. The bench therefore compares the full status byte and all four verdicts after every stimulus cycle, with no gap in which an error could hide.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int SR_W = 8;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_SETEN = 3'd1,
        OP_CLREN = 3'd2,
        OP_SRWR  = 3'd3,
        OP_MEMWR = 3'd4
    } op_e;

    typedef struct packed {
        logic       frz;
        logic [1:0] psz;
        logic       wel;
        logic       wip;
    } sr_t;

    typedef struct packed {
        logic mem_go;
        logic mem_deny;
        logic sr_go;
        logic sr_deny;
    } verdict_t;

    typedef struct packed {
        logic       set_wel;
        logic       clr_wel;
        logic       load;
        logic       start;
        logic       frz_new;
        logic [1:0] psz_new;
    } upd_t;

    function automatic logic [SR_W-1:0] pack_status(input sr_t s);
        logic [SR_W-1:0] b;
        b      = '0;
        b[0]   = s.wip;
        b[1]   = s.wel;
        b[3:2] = s.psz;
        b[7]   = s.frz;
        return b;
    endfunction

    function automatic op_e to_op(input logic [2:0] code);
        op_e o;
        case (code)
            3'd1:    o = OP_SETEN;
            3'd2:    o = OP_CLREN;
            3'd3:    o = OP_SRWR;
            3'd4:    o = OP_MEMWR;
            default: o = OP_IDLE;
        endcase
        return o;
    endfunction

    function automatic logic frozen(input sr_t s, input logic pin_n);
        return s.frz & ~pin_n;
    endfunction

endpackage

// File: rtl/sr_region_chk.sv
module sr_region_chk
    import sr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        psz,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int MSB = ADDR_W - 1;

    logic top_half;
    logic top_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign top_half    = addr[MSB];
            assign top_quarter = addr[MSB] & addr[MSB-1];
        end else begin : g_narrow
            assign top_half    = addr[MSB];
            assign top_quarter = addr[MSB];
        end
    endgenerate

    always_comb begin
        case (psz)
            2'b00:   hit = 1'b0;
            2'b01:   hit = top_quarter;
            2'b10:   hit = top_half;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_judge.sv
module sr_judge
    import sr_pkg::*;
(
    input  op_e       op,
    input  sr_t       cur,
    input  logic      wp_n,
    input  logic      region_hit,
    input  logic [7:0] data,
    output verdict_t  verdict,
    output upd_t      upd
);
    logic live;
    logic sr_ok;
    logic mem_ok;

    assign live   = ~cur.wip;
    assign sr_ok  = cur.wel & ~frozen(cur, wp_n);
    assign mem_ok = cur.wel & ~region_hit;

    always_comb begin
        verdict     = '0;
        upd         = '0;
        upd.frz_new = data[7];
        upd.psz_new = data[3:2];
        if (live) begin
            case (op)
                OP_SETEN: upd.set_wel = 1'b1;
                OP_CLREN: upd.clr_wel = 1'b1;
                OP_SRWR: begin
                    if (sr_ok) begin
                        verdict.sr_go = 1'b1;
                        upd.load      = 1'b1;
                        upd.start     = 1'b1;
                    end else begin
                        verdict.sr_deny = 1'b1;
                    end
                end
                OP_MEMWR: begin
                    if (mem_ok) begin
                        verdict.mem_go = 1'b1;
                        upd.start      = 1'b1;
                    end else begin
                        verdict.mem_deny = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sr_bits.sv
module sr_bits
    import sr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  upd_t upd,
    input  logic cyc_done,
    output sr_t  cur
);
    sr_t nxt;

    always_comb begin
        nxt = cur;
        if (cyc_done) begin
            nxt.wip = 1'b0;
            nxt.wel = 1'b0;
        end else begin
            if (upd.start)   nxt.wip = 1'b1;
            if (upd.set_wel) nxt.wel = 1'b1;
            if (upd.clr_wel) nxt.wel = 1'b0;
            if (upd.load) begin
                nxt.frz = upd.frz_new;
                nxt.psz = upd.psz_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    input  logic              cyc_busy,
    output logic              mem_wr_go,
    output logic              mem_wr_deny,
    output logic              sr_wr_go,
    output logic              sr_wr_deny,
    output logic [7:0]        status_byte
);
    sr_t      cur;
    upd_t     upd;
    verdict_t vd_c;
    verdict_t vd_q;
    logic     hit;
    logic     busy_q;
    logic     cyc_done;
    logic     data_unused;

    assign data_unused = ^{cmd_data[6:4], cmd_data[1:0]};

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= cyc_busy;
    end

    assign cyc_done = busy_q & ~cyc_busy & cur.wip;

    sr_region_chk #(.ADDR_W(ADDR_W)) u_region (
        .psz  (cur.psz),
        .addr (cmd_addr),
        .hit  (hit)
    );

    sr_judge u_judge (
        .op         (to_op(cmd_op)),
        .cur        (cur),
        .wp_n       (wp_n),
        .region_hit (hit),
        .data       (cmd_data),
        .verdict    (vd_c),
        .upd        (upd)
    );

    sr_bits u_bits (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .cyc_done (cyc_done),
        .cur      (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) vd_q <= '0;
        else     vd_q <= vd_c;
    end

    assign mem_wr_go   = vd_q.mem_go;
    assign mem_wr_deny = vd_q.mem_deny;
    assign sr_wr_go    = vd_q.sr_go;
    assign sr_wr_deny  = vd_q.sr_deny;
    assign status_byte = pack_status(cur);
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       mem_wr_go,
    input logic       mem_wr_deny,
    input logic       sr_wr_go,
    input logic       sr_wr_deny,
    input logic [7:0] status_byte
);
    AST_GO_DENY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_go && mem_wr_deny) && !(sr_wr_go && sr_wr_deny)); // R6

    AST_GO_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_go || sr_wr_go) |-> $past(status_byte[1])); // R7

    AST_GO_SETS_WIP: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_go || sr_wr_go) |-> status_byte[0]); // R7

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        sr_wr_go |-> !$past(status_byte[7] && !wp_n)); // R5

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        $past(status_byte[0]) |-> !(mem_wr_go || mem_wr_deny || sr_wr_go || sr_wr_deny)); // R9

    AST_PSZ_ONLY_ON_GO: assert property (@(posedge clk) disable iff (rst)
        (status_byte[7:2] != $past(status_byte[7:2])) |-> sr_wr_go); // R5

    AST_DENY_NO_WIP: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_deny || sr_wr_deny) |-> !status_byte[0]); // R8
endmodule

bind sr_guard sr_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wp_n        (wp_n),
    .mem_wr_go   (mem_wr_go),
    .mem_wr_deny (mem_wr_deny),
    .sr_wr_go    (sr_wr_go),
    .sr_wr_deny  (sr_wr_deny),
    .status_byte (status_byte)
);

// File: tb/sr_guard_tb.sv
module sr_guard_tb;
    localparam int AW = 16;
    localparam int NV = 38;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          wp_n = 1'b1;
    logic          cyc_busy = 1'b0;
    logic          mem_wr_go, mem_wr_deny, sr_wr_go, sr_wr_deny;
    logic [7:0]    status_byte;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    sr_guard #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .wp_n(wp_n), .cyc_busy(cyc_busy),
        .mem_wr_go(mem_wr_go), .mem_wr_deny(mem_wr_deny),
        .sr_wr_go(sr_wr_go), .sr_wr_deny(sr_wr_deny),
        .status_byte(status_byte)
    );

    // op, addr, data, wp_n, busy, expected status, expected {mem_go,mem_deny,sr_go,sr_deny}
    localparam logic [40:0] VEC [NV] = '{
        {3'd4, 16'h0010, 8'h00, 1'b1, 1'b0, 8'h00, 4'b0100}, // R8 no latch
        {3'd3, 16'h0000, 8'h8C, 1'b1, 1'b0, 8'h00, 4'b0001}, // R4
        {3'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h02, 4'b0000}, // R3
        {3'd4, 16'h0010, 8'h00, 1'b1, 1'b0, 8'h03, 4'b1000}, // R7
        {3'd1, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h03, 4'b0000}, // R9
        {3'd4, 16'h0020, 8'h00, 1'b1, 1'b1, 8'h03, 4'b0000}, // R9
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h00, 4'b0000}, // R10
        {3'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h02, 4'b0000}, // R3
        {3'd3, 16'h0000, 8'h04, 1'b1, 1'b0, 8'h07, 4'b0010}, // R5
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h07, 4'b0000}, // R11
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h04, 4'b0000}, // R10
        {3'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h06, 4'b0000}, // R3
        {3'd4, 16'hC000, 8'h00, 1'b1, 1'b0, 8'h06, 4'b0100}, // R6 quarter
        {3'd4, 16'hBFFF, 8'h00, 1'b1, 1'b0, 8'h07, 4'b1000}, // R6
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h07, 4'b0000}, // R11
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h04, 4'b0000}, // R10
        {3'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h06, 4'b0000}, // R3
        {3'd3, 16'h0000, 8'h88, 1'b1, 1'b0, 8'h8B, 4'b0010}, // R5
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h8B, 4'b0000}, // R11
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h88, 4'b0000}, // R10
        {3'd1, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h8A, 4'b0000}, // R3
        {3'd3, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h8A, 4'b0001}, // R5 frozen
        {3'd4, 16'h8000, 8'h00, 1'b0, 1'b0, 8'h8A, 4'b0100}, // R6 half
        {3'd4, 16'h7FFF, 8'h00, 1'b0, 1'b0, 8'h8B, 4'b1000}, // R6
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h8B, 4'b0000}, // R11
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h88, 4'b0000}, // R10
        {3'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h8A, 4'b0000}, // R3
        {3'd3, 16'h0000, 8'h0C, 1'b1, 1'b0, 8'h0F, 4'b0010}, // R5 pin high
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h0F, 4'b0000}, // R11
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h0C, 4'b0000}, // R10
        {3'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h0E, 4'b0000}, // R3
        {3'd4, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h0E, 4'b0100}, // R6 whole
        {3'd2, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h0C, 4'b0000}, // R3 clear
        {3'd4, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h0C, 4'b0100}, // R8
        {3'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h0E, 4'b0000}, // R3
        {3'd3, 16'h0000, 8'h73, 1'b1, 1'b0, 8'h03, 4'b0010}, // R2 bits 6:4
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h03, 4'b0000}, // R11
        {3'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h00, 4'b0000}  // R10
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got status=%h verdict=%b, want status=%h verdict=%b",
                     req, act[11:4], act[3:0], exp[11:4], exp[3:0]);
        end
    endtask

    function automatic logic [11:0] observed();
        return {status_byte, mem_wr_go, mem_wr_deny, sr_wr_go, sr_wr_deny};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", observed(), 12'h000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", observed(), 12'h000);

        for (int i = 0; i < NV; i++) begin
            {cmd_op, cmd_addr, cmd_data, wp_n, cyc_busy} = VEC[i][40:12];
            @(negedge clk);
            check($sformatf("R2/R11 vector %0d", i), observed(), VEC[i][11:0]);
        end

        // R3 undefined codes are idle
        cmd_op = 3'd7; wp_n = 1'b1; cyc_busy = 1'b0;
        @(negedge clk);
        check("R3 code 7 idle", observed(), 12'h000);

        // R9 clear-enable ignored while busy
        cmd_op = 3'd1; @(negedge clk);
        cmd_op = 3'd4; cmd_addr = 16'h0001; @(negedge clk);
        check("R7 go", observed(), {8'h03, 4'b1000});
        cmd_op = 3'd2; cyc_busy = 1'b1; @(negedge clk);
        check("R9 clear ignored", observed(), {8'h03, 4'b0000});

        // R1 reset in mid-cycle
        cmd_op = 3'd0; rst = 1'b1; @(negedge clk);
        check("R1 mid reset", observed(), 12'h000);
        rst = 1'b0; cyc_busy = 1'b0; @(negedge clk);
        check("R10 no spurious", observed(), 12'h000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule